// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a logical address, made of a 16-bit segment selector and a 32-bit offset, into a 32-bit linear address. It handles one translation at a time. A request is taken on a valid/ready handshake. The result comes back as a one-cycle pulse that carries either a linear address or a fault code.

In protected mode the selector picks one of two descriptor tables, global or local, and an entry within that table. The block reads the 8-byte descriptor as two 32-bit words over a simple read port. It then checks the descriptor's presence flag and its limit, which is scaled by the granularity flag, and adds the descriptor base to the offset. In legacy mode it makes no memory access: the selector is shifted left by four and added to the offset, and the sum is kept to 20 bits.

Top module: `seg_translator`

## Requirements
- R1: The selector is decoded as index = sel[15:3] and table flag = sel[2]; the requested privilege bits sel[1:0] have no effect on the descriptor address or the result.
- R2: Table flag 0 takes `gtab_base` as the table base and table flag 1 takes `ltab_base`.
- R3: The descriptor is read as two words: the low word from table base + index*8 first, then the high word from that address + 4.
- R4: The descriptor base is low[31:16] for base[15:0], high[7:0] for base[23:16] and high[31:24] for base[31:24]. A successful protected result is (base + offset) modulo 2^32, with fault code 0.
- R5: A descriptor with presence bit high[15] = 0 gives fault code 1 and a linear address of 0.
- R6: The 20-bit limit is low[15:0] for limit[15:0] and high[19:16] for limit[19:16]. With granularity bit high[23] = 0, an offset greater than the limit gives fault code 2 and address 0. An offset equal to the limit is accepted.
- R7: With granularity 1, the effective limit is the 20-bit limit followed by twelve 1 bits, and it is compared the same way.
- R8: With `req_prot` = 0, the result is ({sel, 4'b0} + offset) modulo 2^20, zero-extended, with fault code 0. No memory read is made, and the result appears one cycle after acceptance.
- R9: `req_ready` is high only when no translation is in flight. `mem_addr` stays steady while `mem_req` waits for `mem_gnt`.
- R10: `res_valid` is a single-cycle pulse, one per accepted request, in acceptance order.
- R11: When the presence bit is 0 and the offset is also over the limit, fault code 1 is reported.
- R12: After reset, `req_ready` is 1 and `res_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_prot | input | 1 | 1 = protected mode, 0 = legacy shift-and-add |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| gtab_base | input | 32 | Global descriptor table base |
| ltab_base | input | 32 | Local descriptor table base |
| mem_req | output | 1 | Descriptor word read request |
| mem_gnt | input | 1 | Read request accepted |
| mem_addr | output | 32 | Byte address of the descriptor word |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read data word |
| res_valid | output | 1 | Result pulse |
| res_lin | output | 32 | Linear address, 0 on fault |
| res_fault | output | 2 | 0 none, 1 segment absent, 2 over limit |

## Verification
The bench probes the edges of the limit check. It tests an offset exactly at the limit and one past it, both granularities, and the 1 MB boundary. A design with an off-by-one or an unscaled limit would fault on legal offsets or let illegal ones through. Fault priority is tested with a descriptor that is both absent and over its limit; a wrong ordering would report a limit fault there. The bench uses the highest index in the local table, varies the privilege bits, and exercises legacy wraparound at 20 bits and base-plus-offset wraparound at 32 bits. These expose a wrong table select, a missing ×8 scale, a carry leaking past bit 19, or a stray memory read in legacy mode. The read port stalls its grant on a fixed pattern, which shows whether the address is held while the read waits.

// File: rtl/segx_pkg.sv
`timescale 1ns/1ps
package segx_pkg;
   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_LIMIT  = 2'd2
   } seg_fault_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_LO,
      ST_WT_LO,
      ST_RD_HI,
      ST_WT_HI,
      ST_DONE
   } seg_state_e;

   typedef struct packed {
      logic [31:0] base;
      logic [19:0] lim;
      logic        present;
      logic        gran;
   } seg_desc_t;
endpackage

// File: rtl/seg_desc_unpack.sv
`timescale 1ns/1ps
module seg_desc_unpack
   import segx_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int P_BIT   = 15,
   parameter int G_BIT   = 23
) (
   input  logic [WORD_W-1:0] lo_word,
   input  logic [WORD_W-1:0] hi_word,
   output seg_desc_t         desc
);
   logic unused_attr;

   always_comb begin
      desc.base    = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
      desc.lim     = {hi_word[19:16], lo_word[15:0]};
      desc.present = hi_word[P_BIT];
      desc.gran    = hi_word[G_BIT];
   end

   assign unused_attr = ^{hi_word[22:20], hi_word[14:8]};

   if (WORD_W != 32) begin : g_bad_word
      $error("seg_desc_unpack: descriptor words must be 32 bits");
   end
endmodule

// File: rtl/seg_limit_chk.sv
`timescale 1ns/1ps
module seg_limit_chk #(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12
) (
   input  logic [ADDR_W-1:0] off,
   input  logic [LIM_W-1:0]  lim,
   input  logic              gran,
   output logic              over
);
   localparam int EFF_W = LIM_W + GRAN_SHIFT;

   logic [EFF_W-1:0] eff_lim;

   always_comb begin
      if (gran)
         eff_lim = {lim, {GRAN_SHIFT{1'b1}}};
      else
         eff_lim = EFF_W'(lim);
      over = (off > eff_lim);
   end

   if (EFF_W != ADDR_W) begin : g_bad_eff
      $error("seg_limit_chk: scaled limit width must equal address width");
   end
endmodule

// File: rtl/seg_real_addr.sv
`timescale 1ns/1ps
module seg_real_addr #(
   parameter int SEL_W     = 16,
   parameter int ADDR_W    = 32,
   parameter int RM_SHIFT  = 4,
   parameter int RM_ADDR_W = 20,
   parameter bit REAL_WRAP = 1'b1
) (
   input  logic [SEL_W-1:0]     sel,
   input  logic [RM_ADDR_W-1:0] off,
   output logic [ADDR_W-1:0]    lin
);
   localparam int SUM_W = RM_ADDR_W + 1;

   logic [SUM_W-1:0] sum;

   assign sum = SUM_W'({sel, {RM_SHIFT{1'b0}}}) + SUM_W'(off);

   if (REAL_WRAP) begin : g_wrap
      assign lin = ADDR_W'(sum[RM_ADDR_W-1:0]);
   end else begin : g_carry
      assign lin = ADDR_W'(sum);
   end

   if (SEL_W + RM_SHIFT != RM_ADDR_W) begin : g_bad_rm
      $error("seg_real_addr: shifted selector must fill the legacy address");
   end
endmodule

// File: rtl/seg_fetch_ctl.sv
`timescale 1ns/1ps
module seg_fetch_ctl
   import segx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_prot,
   input  logic              start_real,
   input  logic [ADDR_W-1:0] desc_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] lo_q,
   output logic [WORD_W-1:0] hi_q,
   output logic              idle,
   output logic              done
);
   localparam int STEP = WORD_W / 8;

   seg_state_e        state;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         addr_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start_prot) begin
                  state  <= ST_RD_LO;
                  addr_q <= desc_addr;
               end else if (start_real) begin
                  state <= ST_DONE;
               end
            end
            ST_RD_LO: if (mem_gnt) state <= ST_WT_LO;
            ST_WT_LO: begin
               if (mem_rvalid) begin
                  lo_q  <= mem_rdata;
                  state <= ST_RD_HI;
               end
            end
            ST_RD_HI: if (mem_gnt) state <= ST_WT_HI;
            ST_WT_HI: begin
               if (mem_rvalid) begin
                  hi_q  <= mem_rdata;
                  state <= ST_DONE;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req  = (state == ST_RD_LO) || (state == ST_RD_HI);
   assign mem_addr = (state == ST_RD_HI) ? addr_q + ADDR_W'(STEP) : addr_q;
   assign idle     = (state == ST_IDLE);
   assign done     = (state == ST_DONE);
endmodule

// File: rtl/seg_translator.sv
`timescale 1ns/1ps
module seg_translator
   import segx_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SEL_W      = 16,
   parameter int WORD_W     = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int DESC_BYTES = 8,
   parameter int RM_SHIFT   = 4,
   parameter int RM_ADDR_W  = 20,
   parameter bit REAL_WRAP  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_prot,
   input  logic [SEL_W-1:0]  req_sel,
   input  logic [ADDR_W-1:0] req_off,
   input  logic [ADDR_W-1:0] gtab_base,
   input  logic [ADDR_W-1:0] ltab_base,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              res_valid,
   output logic [ADDR_W-1:0] res_lin,
   output logic [1:0]        res_fault
);
   localparam int DESC_SHIFT = $clog2(DESC_BYTES);
   localparam int TI_BIT     = 2;
   localparam int IDX_LSB    = TI_BIT + 1;

   logic              accept;
   logic              idle;
   logic              done;
   logic              cap_prot;
   logic [SEL_W-1:0]  cap_sel;
   logic [ADDR_W-1:0] cap_off;
   logic [ADDR_W-1:0] tab_base;
   logic [ADDR_W-1:0] desc_addr;
   logic [WORD_W-1:0] lo_q;
   logic [WORD_W-1:0] hi_q;
   seg_desc_t         desc;
   logic              over;
   logic [ADDR_W-1:0] real_lin;
   seg_fault_e        flt;

   assign req_ready = idle;
   assign accept    = req_valid && idle;
   assign tab_base  = req_sel[TI_BIT] ? ltab_base : gtab_base;
   assign desc_addr = tab_base + (ADDR_W'(req_sel[SEL_W-1:IDX_LSB]) << DESC_SHIFT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_prot <= 1'b0;
         cap_sel  <= '0;
         cap_off  <= '0;
      end else if (accept) begin
         cap_prot <= req_prot;
         cap_sel  <= req_sel;
         cap_off  <= req_off;
      end
   end

   seg_fetch_ctl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_prot (accept && req_prot),
      .start_real (accept && !req_prot),
      .desc_addr  (desc_addr),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .lo_q       (lo_q),
      .hi_q       (hi_q),
      .idle       (idle),
      .done       (done)
   );

   seg_desc_unpack #(.WORD_W(WORD_W)) u_unpack (
      .lo_word (lo_q),
      .hi_word (hi_q),
      .desc    (desc)
   );

   seg_limit_chk #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .GRAN_SHIFT(GRAN_SHIFT)) u_lim (
      .off  (cap_off),
      .lim  (desc.lim),
      .gran (desc.gran),
      .over (over)
   );

   seg_real_addr #(
      .SEL_W(SEL_W), .ADDR_W(ADDR_W), .RM_SHIFT(RM_SHIFT),
      .RM_ADDR_W(RM_ADDR_W), .REAL_WRAP(REAL_WRAP)
   ) u_real (
      .sel (cap_sel),
      .off (cap_off[RM_ADDR_W-1:0]),
      .lin (real_lin)
   );

   always_comb begin
      if (!cap_prot)
         flt = FLT_NONE;
      else if (!desc.present)
         flt = FLT_ABSENT;
      else if (over)
         flt = FLT_LIMIT;
      else
         flt = FLT_NONE;
   end

   assign res_valid = done;
   assign res_fault = flt;
   assign res_lin   = !cap_prot ? real_lin :
                      (flt != FLT_NONE) ? '0 : desc.base + cap_off;

   if (ADDR_W != 32 || SEL_W != 16) begin : g_bad_fmt
      $error("seg_translator: descriptor format needs 32-bit addresses and 16-bit selectors");
   end
endmodule

// File: rtl/seg_translator_chk.sv
`timescale 1ns/1ps
module seg_translator_chk #(
   parameter int ADDR_W = 32,
   parameter int RM_W   = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_prot,
   input logic              mem_req,
   input logic              mem_gnt,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              res_valid,
   input logic [ADDR_W-1:0] res_lin,
   input logic [1:0]        res_fault
);
   logic mode_prot;
   logic real_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_prot <= 1'b0;
         real_busy <= 1'b0;
      end else begin
         if (req_valid && req_ready) begin
            mode_prot <= req_prot;
            real_busy <= !req_prot;
         end else if (res_valid) begin
            real_busy <= 1'b0;
         end
      end
   end

   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req); // R9
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr)); // R9
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready); // R9
   AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R10
   AST_RES_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !req_ready); // R10
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && res_fault != 2'd0 |-> res_lin == '0); // R5
   AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_fault != 2'd3); // R6
   AST_REAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !mode_prot |-> (res_lin >> RM_W) == '0 && res_fault == 2'd0); // R8
   AST_REAL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      real_busy |-> !mem_req); // R8
   AST_REAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_prot |=> res_valid); // R8
endmodule

bind seg_translator seg_translator_chk #(
   .ADDR_W (ADDR_W),
   .RM_W   (RM_ADDR_W + (REAL_WRAP ? 0 : 1))
) u_chk (.*);

// File: tb/sim_seg_translator.sv
`timescale 1ns/1ps
module sim_seg_translator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_prot = 1'b0;
   logic [15:0] req_sel = '0;
   logic [31:0] req_off = '0;
   logic [31:0] gtab_base = 32'h0001_0000;
   logic [31:0] ltab_base = 32'h0020_0000;
   logic        mem_req;
   logic        mem_gnt = 1'b0;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        res_valid;
   logic [31:0] res_lin;
   logic [1:0]  res_fault;

   always #10 clk = ~clk;

   seg_translator u0 (.*);

   typedef struct {
      string       req;
      bit          prot;
      logic [31:0] lin;
      logic [1:0]  flt;
      int          rd0;
   } exp_t;

   exp_t        sb[$];
   int          n_chk = 0;
   int          n_fail = 0;
   int          rd_cnt = 0;
   bit          rd_phase = 1'b0;
   bit          finished = 1'b0;
   logic [31:0] cur_lo = '0;
   logic [31:0] cur_hi = '0;
   logic [31:0] exp_addr = '0;
   int          cyc = 0;
   bit          pend = 1'b0;
   logic [31:0] paddr = '0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_desc(logic [31:0] base, logic [19:0] lim, bit p, bit g);
      logic [31:0] lo, hi;
      lo = {base[15:0], lim[15:0]};
      hi = {base[31:24], g, 1'b1, 2'b00, lim[19:16], p, 2'b11, 1'b1, 4'h2, base[23:16]};
      return {hi, lo};
   endfunction

   // memory model: grant stalls on a fixed pattern, data one cycle after grant
   always @(posedge clk) begin
      cyc        <= cyc + 1;
      mem_gnt    <= (cyc % 3) != 0;
      mem_rvalid <= 1'b0;
      if (mem_req && mem_gnt) begin
         pend  <= 1'b1;
         paddr <= mem_addr;
      end else if (pend) begin
         pend       <= 1'b0;
         mem_rvalid <= 1'b1;
         mem_rdata  <= (paddr == exp_addr) ? cur_lo :
                       (paddr == exp_addr + 32'd4) ? cur_hi : 32'hDEAD_BEEF;
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_gnt) begin
            rd_cnt++;
            chk("R3 descriptor word address", mem_addr, exp_addr + (rd_phase ? 32'd4 : 32'd0));
            rd_phase = !rd_phase;
         end
         if (res_valid) begin
            if (sb.size() == 0) begin
               chk("R10 unexpected result", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk({e.req, " linear"}, res_lin, e.lin);
               chk({e.req, " fault"}, {30'd0, res_fault}, {30'd0, e.flt});
               chk("R9 busy while result", {31'd0, req_ready}, 32'd0);
               chk({e.req, " read count R8/R3"}, rd_cnt - e.rd0, e.prot ? 32'd2 : 32'd0);
            end
         end
      end
   end

   task automatic issue(string req, bit prot, logic [15:0] sel, logic [31:0] off,
                        logic [63:0] d, logic [31:0] daddr, logic [31:0] elin, logic [1:0] eflt);
      exp_t e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cur_lo   = d[31:0];
      cur_hi   = d[63:32];
      exp_addr = daddr;
      e.req  = req;
      e.prot = prot;
      e.lin  = elin;
      e.flt  = eflt;
      e.rd0  = rd_cnt;
      sb.push_back(e);
      req_prot  = prot;
      req_sel   = sel;
      req_off   = off;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired, pending=%0d expected=0", sb.size());
      finish_run();
   end

   initial begin
      logic [63:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R12 reset ready", {31'd0, req_ready}, 32'd1);
      chk("R12 reset result", {31'd0, res_valid}, 32'd0);
      chk("R12 reset read", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;

      d = mk_desc(32'h1234_5678, 20'hFFFFF, 1'b1, 1'b0);
      issue("R4 global base+offset", 1'b1, 16'h002B, 32'h0000_0100, d, 32'h0001_0028, 32'h1234_5778, 2'd0);
      issue("R1 privilege bits ignored", 1'b1, 16'h0028, 32'h0000_0100, d, 32'h0001_0028, 32'h1234_5778, 2'd0);
      issue("R6 1MB limit edge", 1'b1, 16'h0028, 32'h000F_FFFF, d, 32'h0001_0028, 32'h1244_5677, 2'd0);
      issue("R6 past 1MB", 1'b1, 16'h0028, 32'h0010_0000, d, 32'h0001_0028, 32'h0, 2'd2);

      d = mk_desc(32'h0000_0000, 20'h00010, 1'b1, 1'b0);
      issue("R2 local table top index", 1'b1, 16'hFFFC, 32'h0000_0010, d, 32'h0020_FFF8, 32'h0000_0010, 2'd0);
      issue("R6 offset one past limit", 1'b1, 16'hFFFD, 32'h0000_0011, d, 32'h0020_FFF8, 32'h0, 2'd2);

      d = mk_desc(32'h0000_0000, 20'h00010, 1'b0, 1'b0);
      issue("R5 absent segment", 1'b1, 16'h0010, 32'h0000_0004, d, 32'h0001_0010, 32'h0, 2'd1);
      issue("R11 absent beats limit", 1'b1, 16'h0010, 32'h0000_0011, d, 32'h0001_0010, 32'h0, 2'd1);

      d = mk_desc(32'h1000_0000, 20'h00001, 1'b1, 1'b1);
      issue("R7 page granular edge", 1'b1, 16'h0008, 32'h0000_1FFF, d, 32'h0001_0008, 32'h1000_1FFF, 2'd0);
      issue("R7 page granular over", 1'b1, 16'h0008, 32'h0000_2000, d, 32'h0001_0008, 32'h0, 2'd2);

      d = mk_desc(32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1);
      issue("R4 base wrap", 1'b1, 16'h000C, 32'h0000_2000, d, 32'h0020_0008, 32'h0000_1000, 2'd0);
      issue("R7 full 4GB limit", 1'b1, 16'h000C, 32'hFFFF_FFFF, d, 32'h0020_0008, 32'hFFFF_EFFF, 2'd0);

      issue("R8 legacy shift add", 1'b0, 16'h1234, 32'h0000_5678, d, 32'hFFFF_FFF0, 32'h0001_79B8, 2'd0);
      issue("R8 legacy 20-bit wrap", 1'b0, 16'hFFFF, 32'hABC0_0010, d, 32'hFFFF_FFF0, 32'h0000_0000, 2'd0);
      issue("R8 legacy after protected", 1'b0, 16'h0001, 32'h0000_0001, d, 32'hFFFF_FFF0, 32'h0000_0011, 2'd0);

      d = mk_desc(32'h0000_4000, 20'h000FF, 1'b1, 1'b0);
      issue("R2 local low index", 1'b1, 16'h0017, 32'h0000_00FF, d, 32'h0020_0010, 32'h0000_40FF, 2'd0);

      repeat (20) @(negedge clk);
      chk("R10 all results seen", sb.size(), 32'd0);
      finish_run();
   end
endmodule